// File: doc/BRIEF.md
# DMA Request FIFO Bridge

This block lets a 16-bit host bus hand data words to the DMA channel of a second processor. The host programs a transfer length, sets a transfer-enable bit, and then writes words one at a time into a data port. Accepted words collect in a small FIFO. The block raises a DMA request toward the consumer each time the buffered words form whole groups of four, but only while the consumer channel and the global DMA enable are both on.

The consumer drains the FIFO through a pop strobe. Each pop takes the head word and counts down the remaining transfer length. When that count reaches zero, the block:
- clears the transfer-enable bit,
- flushes any words still buffered,
- raises a sticky normal-end flag.

The host reads the flag and the FIFO state back through the control register.

Top module: `dreq_fifo_bridge`

## Requirements
- R1: The length register sits at word address 1. A write stores bits 15:2 of the written value, and a read always returns bits 1:0 as zero.
- R2: A write to the data port (word address 2) is ignored while the transfer-enable bit (control bit 0) is clear. The FIFO stays empty.
- R3: Accepted data words are delivered on `pop_data_o` in the order they were written. The head word is presented before each pop.
- R4: The FIFO holds 8 words. The FULL flag (control bit 7) is set when 8 words are held, and data writes made while full are dropped.
- R5: The EMPTY flag (control bit 6) reads 1 exactly when no word is buffered. Reset leaves the control register reading 0x0040.
- R6: `dreq_o` is 1 only when the buffered word count is 4 or 8 and both `chan_en_i` and `glb_dma_en_i` are 1.
- R7: A control write (word address 0) changes only three bits: enable (bit 0), DMA mode (bit 1, driven on `dma_mode_o`) and ROM visibility (bit 2, driven on `rom_vis_o`). FULL, EMPTY and the end flag (bit 5) cannot be written.
- R8: Each pop of a buffered word decrements the remaining transfer count by one. After 4 of 8 words, the length register reads 4.
- R9: The pop that brings the count to zero does four things: it clears the enable bit, sets the end flag (bit 5 and `xfer_end_o`), empties the FIFO and clears FULL.
- R10: A pop while the FIFO is empty is ignored and leaves the remaining count unchanged.
- R11: A control write that sets enable while enable is clear also clears the end flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Host write strobe |
| bus_addr_i | input | 2 | Host word address: 0 control, 1 length, 2 data |
| bus_wdata_i | input | 16 | Host write data |
| bus_rdata_o | output | 16 | Host read data for `bus_addr_i` |
| chan_en_i | input | 1 | Consumer channel enabled with auto-request off |
| glb_dma_en_i | input | 1 | Global DMA enable |
| dreq_o | output | 1 | DMA request to the consumer |
| pop_i | input | 1 | Consumer pops the head word |
| pop_data_o | output | 16 | Head word of the FIFO |
| xfer_end_o | output | 1 | Sticky normal-end flag |
| dma_mode_o | output | 1 | DMA mode bit |
| rom_vis_o | output | 1 | ROM visibility bit |

## Verification
A register write, data push or pop takes effect on the rising edge where it is sampled. The results reach the ports in the following cycle: `bus_rdata_o` is combinational on the stored state, and so are `dreq_o` and `pop_data_o`. The bench therefore drives every stimulus on a falling edge and holds it across exactly one rising edge. It checks results on the next falling edge, after the read address has settled for one time step. Completion is checked exactly one pop early and then on the terminal pop, so an off-by-one in the count is exposed.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 2;

  localparam logic [AW-1:0] A_CTRL = 2'd0;
  localparam logic [AW-1:0] A_LEN  = 2'd1;
  localparam logic [AW-1:0] A_DATA = 2'd2;

  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_DMA   = 1;
  localparam int unsigned B_ROM   = 2;
  localparam int unsigned B_END   = 5;
  localparam int unsigned B_EMPTY = 6;
  localparam int unsigned B_FULL  = 7;
endpackage

// File: rtl/dreq_fifo.sv
module dreq_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 16,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          push_acc, pop_acc;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o   = (cnt_q == CW'(DEPTH));
  assign empty_o  = (cnt_q == '0);
  assign push_acc = push_i && !full_o;
  assign pop_acc  = pop_i && !empty_o;
  assign count_o  = cnt_q;
  assign rdata_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_acc) wp_q <= nxt(wp_q);
      if (pop_acc)  rp_q <= nxt(rp_q);
      case ({push_acc, pop_acc})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      mem_q[i] <= '0;
      else if (push_acc && !flush_i && wp_q == PW'(i)) mem_q[i] <= wdata_i;
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o);
  p_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_empty_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/dreq_regs.sv
module dreq_regs
  import dreq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_acc_i,
  input  logic          full_i,
  input  logic          empty_i,
  output logic          en_o,
  output logic          dma_o,
  output logic          rom_o,
  output logic          end_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  logic          en_q, dma_q, rom_q, end_q;
  logic [DW-1:0] rem_q;
  logic          wr_ctrl, wr_len;

  assign wr_ctrl = wr_i && addr_i == A_CTRL;
  assign wr_len  = wr_i && addr_i == A_LEN;
  assign done_o  = pop_acc_i && rem_q == DW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      dma_q <= 1'b0;
      rom_q <= 1'b0;
      end_q <= 1'b0;
      rem_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata_i[B_EN];
        dma_q <= wdata_i[B_DMA];
        rom_q <= wdata_i[B_ROM];
        if (wdata_i[B_EN] && !en_q) end_q <= 1'b0;
      end
      if (pop_acc_i && rem_q != '0) rem_q <= rem_q - 1'b1;
      if (wr_len) rem_q <= {wdata_i[DW-1:2], 2'b00};
      if (done_o) begin
        en_q  <= 1'b0;
        end_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[B_EN]    = en_q;
        rdata_o[B_DMA]   = dma_q;
        rdata_o[B_ROM]   = rom_q;
        rdata_o[B_END]   = end_q;
        rdata_o[B_EMPTY] = empty_i;
        rdata_o[B_FULL]  = full_i;
      end
      A_LEN:   rdata_o = {rem_q[DW-1:2], 2'b00};
      default: rdata_o = '0;
    endcase
  end

  assign en_o  = en_q;
  assign dma_o = dma_q;
  assign rom_o = rom_q;
  assign end_o = end_q;

  p_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!en_q && end_q && rem_q == '0));
  p_rem_dec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_acc_i && rem_q != '0 && !wr_len) |=> rem_q == $past(rem_q) - 1'b1);
  p_rem_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop_acc_i && !wr_len) |=> $stable(rem_q));
endmodule

// File: rtl/dreq_req_gen.sv
module dreq_req_gen #(
  parameter int unsigned CW    = 4,
  parameter int unsigned GROUP = 4
) (
  input  logic [CW-1:0] count_i,
  input  logic          chan_en_i,
  input  logic          glb_en_i,
  output logic          dreq_o
);
  logic whole;
  assign whole  = (count_i != '0) && ((count_i % CW'(GROUP)) == '0);
  assign dreq_o = whole && chan_en_i && glb_en_i;
endmodule

// File: rtl/dreq_fifo_bridge.sv
module dreq_fifo_bridge
  import dreq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned GROUP = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          chan_en_i,
  input  logic          glb_dma_en_i,
  output logic          dreq_o,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          xfer_end_o,
  output logic          dma_mode_o,
  output logic          rom_vis_o
);
  logic          en, done, full, empty, push, pop_acc;
  logic [CW-1:0] count;

  assign push    = bus_wr_i && bus_addr_i == A_DATA && en;
  assign pop_acc = pop_i && !empty;

  dreq_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .pop_acc_i (pop_acc),
    .full_i    (full),
    .empty_i   (empty),
    .en_o      (en),
    .dma_o     (dma_mode_o),
    .rom_o     (rom_vis_o),
    .end_o     (xfer_end_o),
    .done_o    (done),
    .rdata_o   (bus_rdata_o)
  );

  dreq_fifo #(.DEPTH(DEPTH), .W(DW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (bus_wdata_i),
    .pop_i   (pop_i),
    .flush_i (done),
    .rdata_o (pop_data_o),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  dreq_req_gen #(.CW(CW), .GROUP(GROUP)) u_req (
    .count_i   (count),
    .chan_en_i (chan_en_i),
    .glb_en_i  (glb_dma_en_i),
    .dreq_o    (dreq_o)
  );

  p_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == A_DATA && !en && !pop_i) |=> $stable(count));
  p_dreq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_o |-> (chan_en_i && glb_dma_en_i && !empty));
  p_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (empty && !dreq_o));
endmodule

// File: tb/sim_dreq_fifo_bridge.sv
module sim_dreq_fifo_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        chan_en = 1'b0, glb_en = 1'b0;
  logic        dreq;
  logic        pop = 1'b0;
  logic [15:0] pop_data;
  logic        xend, dma_mode, rom_vis;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  dreq_fifo_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .chan_en_i(chan_en),
    .glb_dma_en_i(glb_en), .dreq_o(dreq), .pop_i(pop), .pop_data_o(pop_data),
    .xfer_end_o(xend), .dma_mode_o(dma_mode), .rom_vis_o(rom_vis)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    bus_rd(2'd0, d); check("R5 reset ctrl", d, 16'h0040);
    bus_rd(2'd1, d); check("R1 reset len", d, 16'h0000);
    check("R6 reset dreq", {15'd0, dreq}, 16'd0);
  endtask

  task automatic t_len_align();
    logic [15:0] d;
    bus_wr(2'd1, 16'h0013);
    bus_rd(2'd1, d); check("R1 len lsbs", d, 16'h0010);
  endtask

  task automatic t_gate();
    logic [15:0] d;
    bus_wr(2'd2, 16'hDEAD);
    bus_rd(2'd0, d); check("R2 gated write keeps empty", d, 16'h0040);
  endtask

  task automatic t_ctrl();
    logic [15:0] d;
    bus_wr(2'd0, 16'h0007);
    bus_rd(2'd0, d); check("R7 ctrl set", d, 16'h0047);
    check("R7 mode pins", {14'd0, dma_mode, rom_vis}, 16'd3);
    bus_wr(2'd0, 16'h00E1);
    bus_rd(2'd0, d); check("R7 ro bits", d, 16'h0041);
  endtask

  task automatic t_fill();
    logic [15:0] d;
    bus_wr(2'd1, 16'd8);
    chan_en = 1'b1; glb_en = 1'b1;
    for (int i = 0; i < 3; i++) bus_wr(2'd2, 16'h1000 + 16'(i));
    #1 check("R6 no dreq at 3", {15'd0, dreq}, 16'd0);
    bus_rd(2'd0, d); check("R5 not empty", d, 16'h0001);
    bus_wr(2'd2, 16'h1003);
    #1 check("R6 dreq at 4", {15'd0, dreq}, 16'd1);
    glb_en = 1'b0;
    #1 check("R6 global off", {15'd0, dreq}, 16'd0);
    glb_en = 1'b1; chan_en = 1'b0;
    #1 check("R6 channel off", {15'd0, dreq}, 16'd0);
    chan_en = 1'b1;
    bus_wr(2'd2, 16'h1004);
    #1 check("R6 no dreq at 5", {15'd0, dreq}, 16'd0);
    for (int i = 5; i < 8; i++) bus_wr(2'd2, 16'h1000 + 16'(i));
    bus_rd(2'd0, d); check("R4 full", d, 16'h0081);
    #1 check("R6 dreq at 8", {15'd0, dreq}, 16'd1);
    bus_wr(2'd2, 16'hBEEF);
    bus_wr(2'd0, 16'h0001);
    bus_rd(2'd0, d); check("R7 full not writable", d, 16'h0081);
  endtask

  task automatic t_drain();
    logic [15:0] d;
    for (int i = 0; i < 7; i++) begin
      #1 check("R3 order", pop_data, 16'h1000 + 16'(i));
      do_pop();
      if (i == 3) begin
        bus_rd(2'd1, d); check("R8 len after 4 pops", d, 16'h0004);
      end
    end
    bus_rd(2'd0, d); check("R9 enable held before last", d, 16'h0001);
    #1 check("R4 overflow dropped", pop_data, 16'h1007);
    do_pop();
    bus_rd(2'd0, d); check("R9 completion ctrl", d, 16'h0060);
    check("R9 end pin", {15'd0, xend}, 16'd1);
    bus_rd(2'd1, d); check("R9 len zero", d, 16'h0000);
  endtask

  task automatic t_end_clear_flush();
    logic [15:0] d;
    bus_wr(2'd0, 16'h0001);
    bus_rd(2'd0, d); check("R11 end cleared", d, 16'h0041);
    check("R11 end pin", {15'd0, xend}, 16'd0);
    bus_wr(2'd1, 16'd4);
    for (int i = 0; i < 6; i++) bus_wr(2'd2, 16'h2000 + 16'(i));
    for (int i = 0; i < 4; i++) do_pop();
    bus_rd(2'd0, d); check("R9 flush on end", d, 16'h0060);
    #1 check("R9 no dreq after flush", {15'd0, dreq}, 16'd0);
  endtask

  task automatic t_empty_pop();
    logic [15:0] d;
    bus_wr(2'd0, 16'h0001);
    bus_wr(2'd1, 16'd8);
    do_pop();
    bus_rd(2'd1, d); check("R10 empty pop count", d, 16'h0008);
    bus_rd(2'd0, d); check("R10 empty pop ctrl", d, 16'h0041);
    bus_wr(2'd2, 16'h3333);
    #1 check("R3 head after empty pop", pop_data, 16'h3333);
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_len_align();
    t_gate();
    t_ctrl();
    t_fill();
    t_drain();
    t_end_clear_flush();
    t_empty_pop();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule